// File: doc/BRIEF.md
# Idle Depth Selection Governor

This block decides, for a single core, which idle depth the core should request the next time it goes idle. Three depths are available: C1 (shallow, quick exit), C2 and C3 (deepest, slowest exit). Each time an idle period ends, the core's power logic pulses a strobe together with the measured length of that period in clock cycles. The governor compares that length with two programmable exit latencies, one for C2 and one for C3. It then updates its choice for the next idle entry.

The governor moves one level deeper only after a run of consecutive long idle periods. From C1 that takes four periods, each longer than the C2 latency. From C2 it takes ten periods, each longer than the C3 latency. It moves one level shallower after a single idle period that does not exceed the exit latency of the depth currently chosen. When C1 was chosen but the period turned out long enough for a deeper state, the governor raises a one-cycle flag marking that choice as wrong.

The controller is a three-state machine whose states are the chosen depth: SEL_C1, SEL_C2 and SEL_C3. Its transitions are PROMOTE_TO_C2 (SEL_C1 to SEL_C2), PROMOTE_TO_C3 (SEL_C2 to SEL_C3), DEMOTE_TO_C1 (SEL_C2 to SEL_C1) and DEMOTE_TO_C2 (SEL_C3 to SEL_C2). Every other strobe is a self-loop, which either advances or clears the run counter.

Top module: `idle_promo_gov`

## Requirements
- R1: After reset, `next_depth` is C1 and `wrong_pick` is 0, and the consecutive-run counter is empty.
- R2: `next_depth` is encoded C1=0, C2=1, C3=2. It changes only in the cycle after a cycle with `idle_done` high, and it holds its value while no strobe arrives.
- R3: In SEL_C1, the fourth consecutive strobe whose `idle_len` exceeds `lat_c2` moves the choice to C2 (PROMOTE_TO_C2). The first three such strobes leave it at C1.
- R4: In SEL_C1, a strobe with `idle_len` not exceeding `lat_c2` clears the run. Four further long strobes are then needed to promote.
- R5: In SEL_C2, the tenth consecutive strobe whose `idle_len` exceeds `lat_c3` moves the choice to C3 (PROMOTE_TO_C3).
- R6: In SEL_C2, a strobe with `idle_len` not exceeding `lat_c2` drops the choice to C1 (DEMOTE_TO_C1) and clears the run.
- R7: In SEL_C2, a strobe with `idle_len` above `lat_c2` but not above `lat_c3` keeps C2 and clears the run.
- R8: In SEL_C3, a strobe with `idle_len` not exceeding `lat_c3` drops the choice to C2 (DEMOTE_TO_C2) with the run cleared. A longer strobe keeps C3.
- R9: `wrong_pick` is high for exactly the cycle after a strobe that arrived while the choice was C1 with `idle_len` above `lat_c2` or above `lat_c3`. It is low in every other cycle.
- R10: All comparisons are strict. An `idle_len` equal to a latency counts as not exceeding it.
- R11: A promotion or demotion never skips a level. C1 and C3 are never adjacent in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_done | input | 1 | One-cycle strobe: an idle period has just ended |
| idle_len | input | DUR_W | Measured length of that idle period, in cycles |
| lat_c2 | input | DUR_W | C2 exit latency, in cycles |
| lat_c3 | input | DUR_W | C3 exit latency, in cycles |
| next_depth | output | 2 | Depth to request on the next idle entry (0=C1, 1=C2, 2=C3) |
| wrong_pick | output | 1 | Pulse: the period just ended was judged a wrong C1 choice |

## Verification
Both results of a strobe are due one clock edge after it: `next_depth` and `wrong_pick` are registered from the strobe cycle. The bench drives each strobe on a falling edge and lowers it at the next falling edge. It compares both outputs at that falling edge, half a cycle after the updating rising edge. Between strobes it inserts idle cycles and confirms that the choice has not moved and that the flag is low. This covers the rule that nothing changes without a strobe and that the flag lasts one cycle.

// File: rtl/idle_gov_pkg.sv
package idle_gov_pkg;
    typedef enum logic [1:0] {
        SEL_C1 = 2'd0,
        SEL_C2 = 2'd1,
        SEL_C3 = 2'd2
    } depth_e;
endpackage

// File: rtl/idle_len_judge.sv
module idle_len_judge #(
    parameter int DUR_W = 16
) (
    input  logic [DUR_W-1:0] len,
    input  logic [DUR_W-1:0] lat_a,
    input  logic [DUR_W-1:0] lat_b,
    output logic             over_a,
    output logic             over_b
);
    // strict comparison: equal length does not count as long (R10)
    always_comb begin
        over_a = (len > lat_a);
        over_b = (len > lat_b);
    end
endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             clear,
    input  logic [RUN_W-1:0] limit,
    output logic             hit
);
    logic [RUN_W-1:0] cnt_q;
    logic [RUN_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        hit     = bump && (cnt_inc == {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || hit)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_inc[RUN_W-1:0];
    end

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit); // R3
endmodule

// File: rtl/idle_promo_gov.sv
module idle_promo_gov #(
    parameter int DUR_W  = 16,
    parameter int C2_RUN = 4,
    parameter int C3_RUN = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_done,
    input  logic [DUR_W-1:0] idle_len,
    input  logic [DUR_W-1:0] lat_c2,
    input  logic [DUR_W-1:0] lat_c3,
    output logic [1:0]       next_depth,
    output logic             wrong_pick
);
    import idle_gov_pkg::*;

    localparam int RUN_MAX = (C2_RUN > C3_RUN) ? C2_RUN : C3_RUN;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    depth_e           cur_q, cur_d;
    logic             over_c2, over_c3;
    logic             run_bump, run_clear, run_hit;
    logic [RUN_W-1:0] run_limit;
    logic             wrong_d;

    idle_len_judge #(.DUR_W(DUR_W)) u_judge (
        .len    (idle_len),
        .lat_a  (lat_c2),
        .lat_b  (lat_c3),
        .over_a (over_c2),
        .over_b (over_c3)
    );

    run_counter #(.RUN_W(RUN_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (run_bump),
        .clear (run_clear),
        .limit (run_limit),
        .hit   (run_hit)
    );

    always_comb begin
        run_limit = (cur_q == SEL_C1) ? RUN_W'(C2_RUN) : RUN_W'(C3_RUN);
    end

    // next-state logic
    always_comb begin
        cur_d     = cur_q;
        run_bump  = 1'b0;
        run_clear = 1'b0;
        if (idle_done) begin
            unique case (cur_q)
                SEL_C1: begin
                    if (over_c2) begin
                        run_bump = 1'b1;
                        if (run_hit) cur_d = SEL_C2;      // PROMOTE_TO_C2
                    end else begin
                        run_clear = 1'b1;
                    end
                end
                SEL_C2: begin
                    if (!over_c2) begin
                        cur_d     = SEL_C1;               // DEMOTE_TO_C1
                        run_clear = 1'b1;
                    end else if (over_c3) begin
                        run_bump = 1'b1;
                        if (run_hit) cur_d = SEL_C3;      // PROMOTE_TO_C3
                    end else begin
                        run_clear = 1'b1;
                    end
                end
                SEL_C3: begin
                    run_clear = 1'b1;
                    if (!over_c3) cur_d = SEL_C2;         // DEMOTE_TO_C2
                end
                default: begin
                    cur_d     = SEL_C1;
                    run_clear = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= SEL_C1;
        else
            cur_q <= cur_d;
    end

    // output process
    always_comb begin
        wrong_d = idle_done && (cur_q == SEL_C1) && (over_c2 || over_c3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wrong_pick <= 1'b0;
        else
            wrong_pick <= wrong_d;
    end

    assign next_depth = cur_q;

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_done |=> $stable(next_depth)); // R2
    AST_NO_LEVEL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (next_depth == 2'd0) |=> (next_depth != 2'd2)); // R11
    AST_NO_SKIP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (next_depth == 2'd2) |=> (next_depth != 2'd0)); // R11
    AST_C3_SHORT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_done && next_depth == 2'd2 && idle_len <= lat_c3) |=> (next_depth == 2'd1)); // R8
    AST_C2_SHORT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_done && next_depth == 2'd1 && idle_len <= lat_c2) |=> (next_depth == 2'd0)); // R6
    AST_FLAG_ONLY_C1: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_done || next_depth != 2'd0) |=> !wrong_pick); // R9
endmodule

// File: tb/sim_idle_promo_gov.sv
`timescale 1ns/1ps
module sim_idle_promo_gov;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          idle_done;
    logic [DW-1:0] idle_len, lat_c2, lat_c3;
    logic [1:0]    next_depth;
    logic          wrong_pick;

    int n_vec = 0;
    int n_bad = 0;
    int m_depth;
    int m_run;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    idle_promo_gov #(.DUR_W(DW), .C2_RUN(4), .C3_RUN(10)) u0 (
        .clk(clk), .rst_n(rst_n), .idle_done(idle_done), .idle_len(idle_len),
        .lat_c2(lat_c2), .lat_c3(lat_c3), .next_depth(next_depth), .wrong_pick(wrong_pick)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        idle_done = 1'b0;
        idle_len  = '0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n   = 1'b1;
        m_depth = 0;
        m_run   = 0;
        @(negedge clk);
        check("R1 depth after reset", int'(next_depth), 0);
        check("R1 flag after reset", int'(wrong_pick), 0);
    endtask

    // apply one strobe; model computed from the requirements; check one edge later
    task automatic strobe(input int len, input string tag);
        int  l2, l3, exp_wrong;
        bit  o2, o3;
        l2 = int'(lat_c2);
        l3 = int'(lat_c3);
        o2 = (len > l2);
        o3 = (len > l3);
        exp_wrong = (m_depth == 0 && (o2 || o3)) ? 1 : 0;
        case (m_depth)
            0: if (o2) begin m_run++; if (m_run == 4) begin m_depth = 1; m_run = 0; end end
               else m_run = 0;
            1: if (!o2) begin m_depth = 0; m_run = 0; end
               else if (o3) begin m_run++; if (m_run == 10) begin m_depth = 2; m_run = 0; end end
               else m_run = 0;
            default: begin m_run = 0; if (!o3) m_depth = 1; end
        endcase
        idle_done = 1'b1;
        idle_len  = DW'(len);
        @(negedge clk);
        idle_done = 1'b0;
        check({tag, " depth"}, int'(next_depth), m_depth);
        check({tag, " R9 flag"}, int'(wrong_pick), exp_wrong);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 hold without strobe", int'(next_depth), m_depth);
            check("R9 flag low without strobe", int'(wrong_pick), 0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        lat_c2 = 16'd20;
        lat_c3 = 16'd50;
        do_reset();

        // R3: three long idles stay at C1, fourth promotes
        for (int i = 0; i < 3; i++) strobe(30, "R3 run below four");
        check("R3 still C1", int'(next_depth), 0);
        strobe(30, "R3 fourth long");
        check("R3 promoted to C2", int'(next_depth), 1);
        quiet(3);

        // R6: short idle in C2 demotes
        strobe(20, "R6 R10 equal to C2 latency");
        check("R6 demoted to C1", int'(next_depth), 0);

        // R4: short idle resets run
        for (int i = 0; i < 3; i++) strobe(21, "R4 partial run");
        strobe(5, "R4 short clears");
        for (int i = 0; i < 3; i++) strobe(21, "R4 rebuilt run");
        check("R4 not yet promoted", int'(next_depth), 0);
        strobe(21, "R4 fourth after clear");
        check("R4 promoted", int'(next_depth), 1);

        // R7: medium idle in C2 clears run
        for (int i = 0; i < 9; i++) strobe(51, "R5 partial run");
        strobe(50, "R7 R10 equal to C3 latency");
        check("R7 stays C2", int'(next_depth), 1);
        for (int i = 0; i < 9; i++) strobe(60, "R7 rebuilt run");
        check("R7 not yet C3", int'(next_depth), 1);
        strobe(60, "R5 tenth long");
        check("R5 promoted to C3", int'(next_depth), 2);

        // R8
        strobe(200, "R8 long keeps C3");
        check("R8 stays C3", int'(next_depth), 2);
        strobe(50, "R8 short demotes");
        check("R8 demoted to C2", int'(next_depth), 1);
        strobe(3, "R11 down to C1");
        check("R11 C1 reached", int'(next_depth), 0);

        // near-exhaustive sweep over length classes and latency configs
        for (int cfg = 0; cfg < 4; cfg++) begin
            int lfsr;
            int lens[7];
            case (cfg)
                0: begin lat_c2 = 16'd20; lat_c3 = 16'd50; end
                1: begin lat_c2 = 16'd0;  lat_c3 = 16'd0;  end
                2: begin lat_c2 = 16'd30; lat_c3 = 16'd30; end
                default: begin lat_c2 = 16'd40; lat_c3 = 16'd10; end
            endcase
            do_reset();
            lens[0] = 0;
            lens[1] = int'(lat_c3);
            lens[2] = int'(lat_c3) + 1;
            lens[3] = int'(lat_c2);
            lens[4] = int'(lat_c2) + 1;
            lens[5] = 45;
            lens[6] = 300;
            lfsr = 32'h1ACE + cfg;
            for (int k = 0; k < 1500; k++) begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                if ((lfsr & 15) < 12) strobe(300, "R2 R3 R5 R8 sweep");
                else strobe(lens[(lfsr >> 4) % 7], "R4 R6 R7 R10 sweep");
                if ((lfsr & 63) == 7) quiet(2);
            end
        end

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule